// File: doc/BRIEF.md
# Banked Prioritized Interrupt Handler

This block collects 32 interrupt lines into one bank and picks a single winner among the lines that are pending and not masked. Every line has its own configuration word. That word chooses rising-edge or level sensing, a 5-bit priority, and whether the line belongs to the fast class or the normal class. The block keeps one winner for each class and drives an active-low request output for each class. Software reads the winning line number over a simple register port. Writing a control register then acknowledges that class and lets the bank arbitrate again.

The `IS_PRIMARY` parameter selects a primary bank or a secondary bank. A secondary bank has no fast class and no global gate. Its normal request output, inverted, drives one dedicated line of the primary bank. Software services a cascaded interrupt by acknowledging it first in the secondary bank and then in the primary bank.

Register map (byte addresses):
- 0x00: line mask.
- 0x04: pending lines.
- 0x08: control (write only).
- 0x0C: global gate, bit 0.
- 0x10: normal-class winner.
- 0x14: fast-class winner.
- 0x80 + 4·n: configuration word of line n.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset the mask register at 0x00 reads 0xFFFFFFFF. A mask bit of 1 keeps its line out of arbitration, and a bit of 0 admits it.
- R2: The configuration word of line n is at 0x80 + 4·n. Bit 0 routes the line to the fast class. Bit 1 selects level sensing when 1 and rising-edge sensing when 0. Bits 6:2 hold the priority. The word reads back as written.
- R3: In a secondary bank, configuration bit 0 reads 0 and the line is served by the normal class. The fast output of a secondary bank never asserts.
- R4: Among the eligible lines of a class, the lowest priority value wins, and a tie goes to the lowest line index. The winner register reads bit 31 = 1 and bits 4:0 = line number while a winner is held, and reads 0 otherwise. Normal class is at 0x10, fast class at 0x14.
- R5: A held winner does not change until that class is acknowledged, even if a more urgent line arrives meanwhile.
- R6: Writing the control register with bit 0 set acknowledges the normal class, and with bit 1 set acknowledges the fast class. The value 0x3 acknowledges both. After an acknowledge, the next eligible line is chosen one cycle later.
- R7: A level-sensed line is pending exactly while its input is high. A rising edge on an edge-sensed line latches pending. That latch stays set after the input falls and clears only when that line is acknowledged as the winner of its class.
- R8: In a primary bank the global gate at 0x0C resets to 1, and while it is 1 both outputs stay high. Writing 0 lets the outputs assert. A secondary bank has no gate: it reads 0 and never blocks.
- R9: The cascade line of the primary bank follows the secondary bank's normal request. It raises no request while its mask bit is set. The primary winner is held until the primary bank itself is acknowledged.
- R10: `irq_n` and `fiq_n` are active low. Each is driven low only while its class holds a winner, that class still has an eligible pending line, and the gate is open. A request is seen on the output two clock edges after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_src | input | 32 | Interrupt request inputs, one per line |
| irq_n | output | 1 | Normal-class request, active low |
| fiq_n | output | 1 | Fast-class request, active low |
| irq_num | output | 5 | Line number of the held normal-class winner |
| fiq_num | output | 5 | Line number of the held fast-class winner |

## Verification
An input that rises just after a clock edge is captured at the next edge, and the winner is latched one edge later. The bench therefore samples one cycle after a stimulus and expects no request yet, then samples a second cycle later and expects the request. A register write takes effect at the edge inside the write. So after an acknowledge the outputs are released at once, and the next winner is read one cycle later. The global gate acts combinationally, so the check that follows its release is made right after that write.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int LINES  = 32;
    localparam int IDX_W  = $clog2(LINES);
    localparam int PRIO_W = 5;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NCLS   = 2;   // class 0 normal, class 1 fast

    localparam logic [ADDR_W-1:0] A_MASK = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND = 8'h04;
    localparam logic [ADDR_W-1:0] A_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] A_GATE = 8'h0C;
    localparam logic [ADDR_W-1:0] A_WIN0 = 8'h10;
    localparam logic [ADDR_W-1:0] A_WIN1 = 8'h14;

    // Packed so that fast=bit0, level=bit1, prio=bits 6:2
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              fast;
    } line_cfg_t;

    function automatic logic [DATA_W-1:0] win_word(input logic act, input logic [IDX_W-1:0] num);
        return act ? {1'b1, {(DATA_W-1-IDX_W){1'b0}}, num} : '0;
    endfunction
endpackage

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
    import irq_bank_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] is_level,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] src_q;
    logic [N-1:0] edge_q;
    logic [N-1:0] rise;

    assign rise = src & ~src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            edge_q <= '0;
        end else begin
            src_q  <= src;
            edge_q <= ~is_level & ((edge_q & ~clr) | rise);
        end
    end

    assign pend = (is_level & src_q) | (~is_level & edge_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_bank_pkg::*;
#(
    parameter int N  = LINES,
    parameter int PW = PRIO_W,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    logic [PW-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        for (int n = 0; n < N; n++) begin
            if (cand[n] && (!any || prio[n] < best)) begin
                any  = 1'b1;
                idx  = IW'(n);
                best = prio[n];
            end
        end
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter bit IS_PRIMARY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  irq_src,
    output logic              irq_n,
    output logic              fiq_n,
    output logic [IDX_W-1:0]  irq_num,
    output logic [IDX_W-1:0]  fiq_num
);
    line_cfg_t                      cfg_q [LINES];
    logic [LINES-1:0]               mask_q;
    logic                           gate_q;
    logic                           gm_open;
    logic [LINES-1:0]               pend;
    logic [LINES-1:0]               is_level;
    logic [LINES-1:0]               is_fast;
    logic [LINES-1:0][PRIO_W-1:0]   prio_v;
    logic [LINES-1:0]               elig;
    logic [NCLS-1:0]                ack;
    logic [NCLS-1:0]                cls_act;
    logic [NCLS-1:0]                cls_any;
    logic [NCLS-1:0][IDX_W-1:0]     cls_idx;
    logic [NCLS-1:0][IDX_W-1:0]     cls_num;
    logic [NCLS-1:0][LINES-1:0]     cls_clr;
    logic [LINES-1:0]               clr_all;
    logic                           wr_cfg;

    assign wr_cfg = bus_wr && bus_addr[ADDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            gate_q <= 1'b1;
            for (int n = 0; n < LINES; n++) cfg_q[n] <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MASK) mask_q <= bus_wdata;
            if (bus_addr == A_GATE) gate_q <= bus_wdata[0];
            if (wr_cfg) begin
                cfg_q[bus_addr[IDX_W+1:2]] <= '{
                    prio:  bus_wdata[PRIO_W+1:2],
                    level: bus_wdata[1],
                    fast:  IS_PRIMARY ? bus_wdata[0] : 1'b0
                };
            end
        end
    end

    assign gm_open = IS_PRIMARY ? !gate_q : 1'b1;

    always_comb begin
        for (int n = 0; n < LINES; n++) begin
            is_level[n] = cfg_q[n].level;
            is_fast[n]  = cfg_q[n].fast;
            prio_v[n]   = cfg_q[n].prio;
        end
    end

    assign ack  = (bus_wr && bus_addr == A_CTRL) ? bus_wdata[NCLS-1:0] : '0;
    assign elig = pend & ~mask_q;

    irq_pend_unit #(.N(LINES)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .src      (irq_src),
        .is_level (is_level),
        .clr      (clr_all),
        .pend     (pend)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [LINES-1:0] cand;
        assign cand = elig & ((c == 1) ? is_fast : ~is_fast);

        irq_prio_pick #(.N(LINES), .PW(PRIO_W)) u_pick (
            .cand (cand),
            .prio (prio_v),
            .any  (cls_any[c]),
            .idx  (cls_idx[c])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                cls_act[c] <= 1'b0;
                cls_num[c] <= '0;
            end else if (ack[c]) begin
                cls_act[c] <= 1'b0;
            end else if (!cls_act[c] && cls_any[c]) begin
                cls_act[c] <= 1'b1;
                cls_num[c] <= cls_idx[c];
            end
        end

        assign cls_clr[c] = (ack[c] && cls_act[c]) ? (LINES'(1) << cls_num[c]) : '0;
    end

    assign clr_all = cls_clr[0] | cls_clr[1];

    assign irq_n   = !(cls_act[0] && cls_any[0] && gm_open);
    assign fiq_n   = !(cls_act[1] && cls_any[1] && gm_open);
    assign irq_num = cls_num[0];
    assign fiq_num = cls_num[1];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            bus_rdata = DATA_W'(cfg_q[bus_addr[IDX_W+1:2]]);
        end else begin
            case (bus_addr)
                A_MASK:  bus_rdata = mask_q;
                A_PEND:  bus_rdata = pend;
                A_GATE:  bus_rdata = DATA_W'(IS_PRIMARY && gate_q);
                A_WIN0:  bus_rdata = win_word(cls_act[0], cls_num[0]);
                A_WIN1:  bus_rdata = win_word(cls_act[1], cls_num[1]);
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter bit IS_PRIMARY = 1'b1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       irq_n,
    input logic                       fiq_n,
    input logic [LINES-1:0]           mask_q,
    input logic                       gate_q,
    input logic [NCLS-1:0]            cls_act,
    input logic [NCLS-1:0][IDX_W-1:0] cls_num
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && bus_addr == A_CTRL;

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> mask_q == '1);

    assert_hold_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (cls_act[0] && !(ctrl_wr && bus_wdata[0])) |=> (cls_act[0] && $stable(cls_num[0])));

    assert_hold_fiq_R5: assert property (@(posedge clk) disable iff (rst)
        (cls_act[1] && !(ctrl_wr && bus_wdata[1])) |=> (cls_act[1] && $stable(cls_num[1])));

    assert_ack_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[0]) |=> !cls_act[0]);

    assert_ack_fiq_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[1]) |=> !cls_act[1]);

    assert_irq_needs_winner_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> cls_act[0]);

    assert_fiq_needs_winner_R10: assert property (@(posedge clk) disable iff (rst)
        !fiq_n |-> cls_act[1]);

    if (IS_PRIMARY) begin : g_gate
        assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (rst)
            gate_q |-> (irq_n && fiq_n));
    end
endmodule

bind irq_bank_ctrl irq_bank_chk #(.IS_PRIMARY(IS_PRIMARY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .fiq_n     (fiq_n),
    .mask_q    (mask_q),
    .gate_q    (gate_q),
    .cls_act   (cls_act),
    .cls_num   (cls_num)
);

// File: tb/irq_bank_ctrl_test.sv
`timescale 1ns/1ps
module irq_bank_ctrl_test;
    localparam real HALF = 2.0;   // 250 MHz

    logic        clk = 0;
    logic        rst = 1;
    logic        p_wr = 0, s_wr = 0;
    logic [7:0]  p_addr = 0, s_addr = 0;
    logic [31:0] p_wdata = 0, s_wdata = 0;
    logic [31:0] p_rdata, s_rdata;
    logic [31:0] p_src = 0, s_src = 0;
    logic        irq_n, fiq_n, sec_irq_n, sec_fiq_n;
    logic [4:0]  irq_num, fiq_num, s_irq_num, s_fiq_num;
    logic [31:0] p_mask = 32'hFFFF_FFFF;
    logic [31:0] rv;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #(HALF) clk = ~clk;

    irq_bank_ctrl #(.IS_PRIMARY(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_wr(p_wr), .bus_addr(p_addr), .bus_wdata(p_wdata),
        .bus_rdata(p_rdata), .irq_src({p_src[31:1], ~sec_irq_n}),
        .irq_n(irq_n), .fiq_n(fiq_n), .irq_num(irq_num), .fiq_num(fiq_num)
    );

    irq_bank_ctrl #(.IS_PRIMARY(1'b0)) sec (
        .clk(clk), .rst(rst), .bus_wr(s_wr), .bus_addr(s_addr), .bus_wdata(s_wdata),
        .bus_rdata(s_rdata), .irq_src(s_src),
        .irq_n(sec_irq_n), .fiq_n(sec_fiq_n), .irq_num(s_irq_num), .fiq_num(s_fiq_num)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit s, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (s) begin s_wr = 1; s_addr = a; s_wdata = d; end
        else   begin p_wr = 1; p_addr = a; p_wdata = d; end
        @(negedge clk);
        s_wr = 0; p_wr = 0;
    endtask

    task automatic rd(input bit s, input logic [7:0] a, output logic [31:0] d);
        if (s) s_addr = a; else p_addr = a;
        #0.5;
        d = s ? s_rdata : p_rdata;
    endtask

    task automatic t_reset;
        rd(0, 8'h00, rv); chk("R1 primary mask reset", rv, 32'hFFFF_FFFF);
        rd(1, 8'h00, rv); chk("R1 secondary mask reset", rv, 32'hFFFF_FFFF);
        rd(0, 8'h0C, rv); chk("R8 gate reset", rv, 32'h1);
        rd(1, 8'h0C, rv); chk("R8 secondary has no gate", rv, 32'h0);
        chk("R10 irq_n idle", irq_n, 1'b1);
        chk("R10 fiq_n idle", fiq_n, 1'b1);
    endtask

    task automatic t_cfg;
        wr(0, 8'h80 + 8'd20, 32'h7F);
        rd(0, 8'h80 + 8'd20, rv); chk("R2 cfg readback line 5", rv, 32'h7F);
        wr(0, 8'h80 + 8'd20, 32'h0);
        wr(1, 8'h80 + 8'd20, 32'h7F);
        rd(1, 8'h80 + 8'd20, rv); chk("R3 secondary fast bit reads 0", rv, 32'h7E);
        wr(1, 8'h80 + 8'd20, 32'h0);
    endtask

    task automatic t_gate_level;
        wr(0, 8'h80 + 8'd12, 32'h0A);           // line 3: level, prio 2
        p_mask[3] = 0; wr(0, 8'h00, p_mask);
        p_src[3] = 1; cyc(3);
        chk("R8 gate closed holds irq_n high", irq_n, 1'b1);
        rd(0, 8'h10, rv); chk("R4 winner line 3 latched", rv, 32'h8000_0003);
        wr(0, 8'h0C, 32'h0);
        chk("R8 gate open asserts irq_n", irq_n, 1'b0);
        p_src[3] = 0; cyc(1);
        chk("R7 level line drops with input", irq_n, 1'b1);
        wr(0, 8'h08, 32'h1);
        rd(0, 8'h10, rv); chk("R6 winner cleared after ack", rv, 32'h0);
    endtask

    task automatic t_priority;
        wr(0, 8'h80 + 8'd16, 32'h1C);           // line 4 prio 7 edge
        wr(0, 8'h80 + 8'd24, 32'h0C);           // line 6 prio 3 edge
        wr(0, 8'h80 + 8'd36, 32'h0C);           // line 9 prio 3 edge
        p_mask[4] = 0; p_mask[6] = 0; p_mask[9] = 0; p_mask[10] = 0;
        wr(0, 8'h00, p_mask);
        p_src[4] = 1; p_src[6] = 1; p_src[9] = 1;
        cyc(1); chk("R10 no request after one edge", irq_n, 1'b1);
        cyc(1); chk("R10 request after two edges", irq_n, 1'b0);
        chk("R4 tie goes to lower index", irq_num, 5'd6);
        p_src[4] = 0; p_src[6] = 0; p_src[9] = 0;
        p_src[10] = 1;                          // line 10 prio 0 edge
        cyc(3);
        chk("R5 held winner unchanged", irq_num, 5'd6);
        chk("R7 edge latch survives input fall", irq_n, 1'b0);
        wr(0, 8'h08, 32'h1); cyc(1);
        rd(0, 8'h10, rv); chk("R6 rearm picks line 10", rv, 32'h8000_000A);
        wr(0, 8'h08, 32'h1); cyc(1);
        rd(0, 8'h10, rv); chk("R4 then line 9", rv, 32'h8000_0009);
        wr(0, 8'h08, 32'h1); cyc(1);
        rd(0, 8'h10, rv); chk("R4 then line 4", rv, 32'h8000_0004);
        wr(0, 8'h08, 32'h1); cyc(1);
        chk("R6 nothing left", irq_n, 1'b1);
        rd(0, 8'h04, rv); chk("R7 edge latches cleared by ack", rv, 32'h0);
        p_src[10] = 0;
    endtask

    task automatic t_fast;
        wr(0, 8'h80 + 8'd48, 32'h05);           // line 12 fast, prio 1 edge
        p_mask[12] = 0; p_mask[13] = 0; wr(0, 8'h00, p_mask);
        p_src[12] = 1; p_src[13] = 1; cyc(1);
        p_src[12] = 0; p_src[13] = 0; cyc(1);
        chk("R2 fast line asserts fiq_n", fiq_n, 1'b0);
        chk("R2 normal line asserts irq_n", irq_n, 1'b0);
        rd(0, 8'h14, rv); chk("R4 fast winner 12", rv, 32'h8000_000C);
        wr(0, 8'h08, 32'h1); cyc(1);
        chk("R6 bit0 releases irq_n", irq_n, 1'b1);
        chk("R6 bit0 leaves fiq_n", fiq_n, 1'b0);
        wr(0, 8'h08, 32'h2); cyc(1);
        chk("R6 bit1 releases fiq_n", fiq_n, 1'b1);
        p_src[12] = 1; p_src[13] = 1; cyc(1);
        p_src[12] = 0; p_src[13] = 0; cyc(1);
        wr(0, 8'h08, 32'h3); cyc(1);
        chk("R6 0x3 releases both", {30'b0, irq_n, fiq_n}, 32'h3);
        rd(0, 8'h14, rv); chk("R6 fast winner empty", rv, 32'h0);
    endtask

    task automatic t_cascade;
        wr(1, 8'h80 + 8'd28, 32'h01);           // sec line 7, fast requested
        rd(1, 8'h80 + 8'd28, rv); chk("R3 secondary line 7 cfg", rv, 32'h0);
        wr(1, 8'h00, ~(32'h1 << 7));
        s_src[7] = 1; cyc(1); s_src[7] = 0; cyc(1);
        chk("R3 secondary serves on irq", sec_irq_n, 1'b0);
        chk("R3 secondary fiq_n stays high", sec_fiq_n, 1'b1);
        chk("R9 cascade line masked", irq_n, 1'b1);
        wr(0, 8'h80, 32'h02);                   // primary line 0 level
        p_mask[0] = 0; wr(0, 8'h00, p_mask); cyc(1);
        chk("R9 cascade reaches primary", irq_n, 1'b0);
        rd(0, 8'h10, rv); chk("R9 primary winner line 0", rv, 32'h8000_0000);
        wr(1, 8'h08, 32'h1);
        chk("R9 secondary released", sec_irq_n, 1'b1);
        cyc(1);
        rd(0, 8'h10, rv); chk("R9 primary holds until own ack", rv, 32'h8000_0000);
        wr(0, 8'h08, 32'h1);
        rd(0, 8'h10, rv); chk("R9 primary ack clears", rv, 32'h0);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        t_reset;
        t_cfg;
        t_gate_level;
        t_priority;
        t_fast;
        t_cascade;
        cyc(2);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule